// File: doc/BRIEF.md
# Coprocessor Two-Beat Load/Store Sequencer

This block connects a host's 32-bit memory beats to a coprocessor register file of sixteen 64-bit entries. It serves both load and store instructions. A long access moves a whole 64-bit entry as two words. A short access moves one word, and which half of the entry it uses depends on the data class. Float values live in the upper half. Integer values live in the lower half, and an integer load sign-extends into the upper half.

The host presents one beat per cycle with `beat_valid`, together with the instruction word and a data-phase flag. In the next cycle the sequencer answers with either "increment" (another word follows) or "done". For a store it also returns the word that goes to memory. A beat that is not a data phase clears the word counter and completes at once, and the host uses it to open every access. On a long access the first beat goes to the upper half when `big_end` is set and to the lower half when it is clear. A further data beat after both words of a long access is reported as a protocol error.

Top module: `cop_ldst_seq`

## Requirements
- R1: After reset no response is signalled, the word counter starts at the first word, and every register entry reads as zero.
- R2: A beat with `data_phase` low answers done with no error and returns zero data. It clears the word counter, so the next long data beat is treated as the first word.
- R3: A long access has instruction bit 22 set. Its first data beat answers increment (`rsp_done` = 0) and its second answers done (`rsp_done` = 1).
- R4: On a long load with `big_end` = 1, the first word is written to bits 63:32 of the entry and the second word to bits 31:0.
- R5: On a long load with `big_end` = 0, the first word is written to bits 31:0 and the second word to bits 63:32.
- R6: A long store returns the halves in the same order as a long load with the same `big_end` setting.
- R7: A short access has instruction bit 22 clear. A short float load (`is_int` = 0) writes bits 63:32 only, and bits 31:0 keep their value.
- R8: A short integer load (`is_int` = 1) writes the word to bits 31:0 and fills bits 63:32 with bit 31 of the word.
- R9: A short float store returns bits 63:32 of the entry, and a short integer store returns bits 31:0. Both answer done.
- R10: A data beat of a long access that arrives after both words answers done with `rsp_err` = 1, writes nothing and returns zero data.
- R11: The entry is selected by instruction bits 15:12. All other instruction bits are ignored, and no other entry changes.
- R12: Each beat produces exactly one response, one clock cycle later. A load beat returns zero data, and no response appears without a beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| beat_valid | input | 1 | A beat is presented this cycle |
| data_phase | input | 1 | 1: data beat; 0: non-data phase that restarts the counter |
| is_store | input | 1 | 1: store (register to memory); 0: load |
| is_int | input | 1 | Data class: 1 integer, 0 float |
| big_end | input | 1 | Host endianness for long accesses; 1 means upper half first |
| insn | input | 32 | Instruction word: bit 22 selects long, bits 15:12 select the entry |
| ld_word | input | 32 | Memory word delivered on a load beat |
| rsp_valid | output | 1 | Response for the beat of the previous cycle |
| rsp_done | output | 1 | 1: done; 0: increment |
| rsp_err | output | 1 | Extra data beat in a long access |
| rsp_data | output | 32 | Word to memory on a store beat, zero otherwise |

## Verification
Long loads and stores are run with both endianness settings and with distinct values in each half. A swapped half or a reversed beat order therefore shows up as a wrong word rather than a coincidental match. Short loads use a negative integer, a positive integer and a float pattern. These separate sign extension from zero fill, and an upper-only write from a full write. Reading the same entry back as float and as integer shows which half was touched. A third long beat, a non-data restart, and accesses to entries 0 and 15 next to an untouched entry separate the error path, the counter clear and the index decoding.

// File: rtl/cop_ldst_pkg.sv
package cop_ldst_pkg;

    // Position of the word within a long access
    typedef enum logic [1:0] {
        WORD_FIRST  = 2'd0,
        WORD_SECOND = 2'd1,
        WORD_SPENT  = 2'd2
    } word_pos_e;

    // Per-beat decision from the word counter
    typedef struct packed {
        logic go;     // the beat moves a word
        logic late;   // the beat is the second word of a long access
        logic done;   // answer done instead of increment
        logic err;    // surplus data beat
    } beat_ctl_t;

endpackage

// File: rtl/cop_ldst_beat.sv
module cop_ldst_beat
    import cop_ldst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      beat_valid,
    input  logic      data_phase,
    input  logic      long_acc,
    output beat_ctl_t ctl,
    output word_pos_e pos
);

    typedef struct packed {
        word_pos_e pos;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        ctl      = '0;
        if (beat_valid) begin
            if (!data_phase) begin
                st_d.pos = WORD_FIRST;
                ctl.done = 1'b1;
            end else if (long_acc) begin
                unique case (st_q.pos)
                    WORD_FIRST: begin
                        ctl.go   = 1'b1;
                        st_d.pos = WORD_SECOND;
                    end
                    WORD_SECOND: begin
                        ctl.go   = 1'b1;
                        ctl.late = 1'b1;
                        ctl.done = 1'b1;
                        st_d.pos = WORD_SPENT;
                    end
                    default: begin
                        ctl.err  = 1'b1;
                        ctl.done = 1'b1;
                    end
                endcase
            end else begin
                ctl.go   = 1'b1;
                ctl.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pos <= WORD_FIRST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos = st_q.pos;

endmodule

// File: rtl/cop_ldst_route.sv
module cop_ldst_route #(
    parameter int W = 32
) (
    input  logic         go,
    input  logic         late,
    input  logic         long_acc,
    input  logic         is_store,
    input  logic         is_int,
    input  logic         big_end,
    input  logic [W-1:0] ld_word,
    input  logic [2*W-1:0] cur_entry,
    output logic         wr_hi,
    output logic         wr_lo,
    output logic [W-1:0] hi_val,
    output logic [W-1:0] lo_val,
    output logic [W-1:0] st_word
);

    logic use_hi;
    logic load_go;

    always_comb begin
        if (long_acc) begin
            use_hi = big_end ^ late;
        end else begin
            use_hi = !is_int;
        end
    end

    assign load_go = go && !is_store;

    always_comb begin
        wr_hi  = 1'b0;
        wr_lo  = 1'b0;
        hi_val = ld_word;
        lo_val = ld_word;
        if (load_go) begin
            if (long_acc) begin
                wr_hi = use_hi;
                wr_lo = !use_hi;
            end else if (is_int) begin
                wr_hi  = 1'b1;
                wr_lo  = 1'b1;
                hi_val = {W{ld_word[W-1]}};
            end else begin
                wr_hi = 1'b1;
            end
        end
    end

    always_comb begin
        st_word = '0;
        if (go && is_store) begin
            st_word = use_hi ? cur_entry[2*W-1:W] : cur_entry[W-1:0];
        end
    end

endmodule

// File: rtl/cop_ldst_rf.sv
module cop_ldst_rf #(
    parameter int W     = 32,
    parameter int NREGS = 16,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IW-1:0]  idx,
    input  logic           wr_hi,
    input  logic           wr_lo,
    input  logic [W-1:0]   hi_val,
    input  logic [W-1:0]   lo_val,
    output logic [2*W-1:0] rd_entry
);

    logic [NREGS-1:0][2*W-1:0] ent_d, ent_q;

    for (genvar g = 0; g < NREGS; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (idx == IW'(g)) begin
                if (wr_hi) ent_d[g][2*W-1:W] = hi_val;
                if (wr_lo) ent_d[g][W-1:0]   = lo_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d[g];
            end
        end
    end

    assign rd_entry = ent_q[idx];

endmodule

// File: rtl/cop_ldst_seq.sv
module cop_ldst_seq
    import cop_ldst_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int IDX_LSB  = 12,
    parameter int LONG_BIT = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic              data_phase,
    input  logic              is_store,
    input  logic              is_int,
    input  logic              big_end,
    input  logic [31:0]       insn,
    input  logic [DATA_W-1:0] ld_word,
    output logic              rsp_valid,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int IDX_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic                long_acc;
    logic [IDX_W-1:0]    reg_idx;
    logic                insn_unused;
    beat_ctl_t           ctl;
    word_pos_e           pos;
    logic [1:0]          beat_state;
    logic                wr_hi, wr_lo;
    logic [DATA_W-1:0]   hi_val, lo_val, st_word;
    logic [2*DATA_W-1:0] cur_entry;

    assign long_acc    = insn[LONG_BIT];
    assign reg_idx     = insn[IDX_LSB +: IDX_W];
    assign insn_unused = ^insn;
    assign beat_state  = pos;

    cop_ldst_beat u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .data_phase (data_phase),
        .long_acc   (long_acc),
        .ctl        (ctl),
        .pos        (pos)
    );

    cop_ldst_route #(.W(DATA_W)) u_route (
        .go        (ctl.go),
        .late      (ctl.late),
        .long_acc  (long_acc),
        .is_store  (is_store),
        .is_int    (is_int),
        .big_end   (big_end),
        .ld_word   (ld_word),
        .cur_entry (cur_entry),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .hi_val    (hi_val),
        .lo_val    (lo_val),
        .st_word   (st_word)
    );

    cop_ldst_rf #(.W(DATA_W), .NREGS(NUM_REGS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (reg_idx),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .hi_val   (hi_val),
        .lo_val   (lo_val),
        .rd_entry (cur_entry)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = beat_valid;
        if (beat_valid) begin
            rsp_d.done = ctl.done;
            rsp_d.err  = ctl.err;
            rsp_d.data = st_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_done  = rsp_q.done;
    assign rsp_err   = rsp_q.err;
    assign rsp_data  = rsp_q.data;

endmodule

// File: rtl/cop_ldst_chk.sv
module cop_ldst_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              beat_valid,
    input logic              data_phase,
    input logic              is_store,
    input logic              long_acc,
    input logic [1:0]        beat_state,
    input logic              rsp_valid,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_data
);

    p_one_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |=> rsp_valid);

    p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |=> !rsp_valid);

    p_load_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !is_store) |=> (rsp_data == '0));

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !data_phase) |=> (rsp_done && !rsp_err && beat_state == 2'd0));

    p_first_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && data_phase && long_acc && beat_state == 2'd0) |=> !rsp_done);

    p_second_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && data_phase && long_acc && beat_state == 2'd1) |=> (rsp_done && !rsp_err));

    p_surplus_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && data_phase && long_acc && beat_state == 2'd2) |=> (rsp_err && rsp_done && rsp_data == '0));

    p_short_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && data_phase && !long_acc) |=> (rsp_done && !rsp_err));

    p_err_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

endmodule

bind cop_ldst_seq cop_ldst_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .data_phase (data_phase),
    .is_store   (is_store),
    .long_acc   (long_acc),
    .beat_state (beat_state),
    .rsp_valid  (rsp_valid),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err),
    .rsp_data   (rsp_data)
);

// File: tb/sim_cop_ldst_seq.sv
`timescale 1ns/1ps
module sim_cop_ldst_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        beat_valid = 1'b0;
    logic        data_phase = 1'b0;
    logic        is_store = 1'b0;
    logic        is_int = 1'b0;
    logic        big_end = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] ld_word = '0;
    logic        rsp_valid, rsp_done, rsp_err;
    logic [31:0] rsp_data;

    always #2.5 clk = ~clk;

    cop_ldst_seq u0 (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .data_phase(data_phase),
        .is_store(is_store), .is_int(is_int), .big_end(big_end), .insn(insn),
        .ld_word(ld_word), .rsp_valid(rsp_valid), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    typedef struct {
        logic        done;
        logic        err;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] m_hi[16];
    logic [31:0] m_lo[16];
    int          m_pos = 0;

    task automatic fail_line(input string tag, input string what);
        n_bad++;
        $display("FAIL %s: %s", tag, what);
    endtask

    // Monitor: compares each response against the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_chk++;
            if (sb.size() == 0) begin
                fail_line("R12", $sformatf("response without beat: got done=%0d err=%0d data=%h, expected none",
                          rsp_done, rsp_err, rsp_data));
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_done !== e.done || rsp_err !== e.err || rsp_data !== e.data)
                    fail_line(e.tag, $sformatf("got done=%0d err=%0d data=%h, expected done=%0d err=%0d data=%h",
                              rsp_done, rsp_err, rsp_data, e.done, e.err, e.data));
            end
        end
    end

    // Driver: presents one beat and queues what the requirements predict
    task automatic beat(input bit dp, input bit st, input bit it, input bit lng,
                        input bit be, input logic [3:0] idx, input logic [31:0] wd,
                        input string tag);
        exp_t e;
        e.tag  = tag;
        e.done = 1'b1;
        e.err  = 1'b0;
        e.data = '0;
        if (!dp) begin
            m_pos = 0;
        end else if (lng) begin
            if (m_pos == 2) begin
                e.err = 1'b1;
            end else begin
                bit hi_sel;
                hi_sel = be ^ (m_pos == 1);
                e.done = (m_pos == 1);
                if (st) e.data = hi_sel ? m_hi[idx] : m_lo[idx];
                else if (hi_sel) m_hi[idx] = wd;
                else m_lo[idx] = wd;
                m_pos++;
            end
        end else begin
            if (st) begin
                e.data = it ? m_lo[idx] : m_hi[idx];
            end else if (it) begin
                m_lo[idx] = wd;
                m_hi[idx] = {32{wd[31]}};
            end else begin
                m_hi[idx] = wd;
            end
        end
        sb.push_back(e);
        beat_valid = 1'b1;
        data_phase = dp;
        is_store   = st;
        is_int     = it;
        big_end    = be;
        // unrelated instruction bits are set to show they are ignored (R11)
        insn       = 32'h0EA0_0A5F | (32'(lng) << 22) | (32'(idx) << 12);
        ld_word    = wd;
        @(negedge clk);
        beat_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        beat_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (sb.size() != 0) begin
            n_chk++;
            fail_line("R12", $sformatf("missing responses: got 0, expected %0d", sb.size()));
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        fail_line("R12", "watchdog expired: got hang, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_hi[i] = '0;
            m_lo[i] = '0;
        end
        repeat (3) @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0) fail_line("R1", $sformatf("got rsp_valid=%0d, expected 0", rsp_valid));
        rst_n = 1'b1;
        @(negedge clk);

        // R1: entries read as zero after reset
        beat(1, 1, 1, 0, 0, 4'd5, '0, "R1");
        beat(1, 1, 0, 0, 0, 4'd5, '0, "R1");

        // R8: negative integer sign-extends
        beat(1, 0, 1, 0, 0, 4'd3, 32'h8000_0001, "R8");
        beat(1, 1, 0, 0, 0, 4'd3, '0, "R8");
        beat(1, 1, 1, 0, 0, 4'd3, '0, "R9");

        // R7: float load leaves the lower half
        beat(1, 0, 0, 0, 0, 4'd3, 32'h1234_5678, "R7");
        beat(1, 1, 1, 0, 0, 4'd3, '0, "R7");
        beat(1, 1, 0, 0, 0, 4'd3, '0, "R9");

        // R3/R4: long big-endian load
        beat(0, 0, 0, 1, 1, 4'd7, '0, "R2");
        beat(1, 0, 0, 1, 1, 4'd7, 32'hAAAA_0001, "R3");
        beat(1, 0, 0, 1, 1, 4'd7, 32'hBBBB_0002, "R3");
        beat(1, 1, 0, 0, 0, 4'd7, '0, "R4");
        beat(1, 1, 1, 0, 0, 4'd7, '0, "R4");

        // R5: long little-endian load
        beat(0, 0, 0, 1, 0, 4'd8, '0, "R2");
        beat(1, 0, 0, 1, 0, 4'd8, 32'hCCCC_0003, "R5");
        beat(1, 0, 0, 1, 0, 4'd8, 32'hDDDD_0004, "R5");
        beat(1, 1, 1, 0, 0, 4'd8, '0, "R5");
        beat(1, 1, 0, 0, 0, 4'd8, '0, "R5");

        // R6: long stores both orders
        beat(0, 1, 0, 1, 1, 4'd8, '0, "R2");
        beat(1, 1, 0, 1, 1, 4'd8, '0, "R6");
        beat(1, 1, 0, 1, 1, 4'd8, '0, "R6");
        beat(0, 1, 0, 1, 0, 4'd7, '0, "R2");
        beat(1, 1, 0, 1, 0, 4'd7, '0, "R6");
        beat(1, 1, 0, 1, 0, 4'd7, '0, "R6");

        // R10: surplus beat flagged and has no effect
        beat(1, 0, 0, 1, 0, 4'd7, 32'hDEAD_BEEF, "R10");
        beat(1, 1, 0, 0, 0, 4'd7, '0, "R10");
        beat(1, 1, 1, 0, 0, 4'd7, '0, "R10");

        // R2: restart makes the next long beat the first again
        beat(0, 0, 0, 1, 1, 4'd9, '0, "R2");
        beat(1, 0, 0, 1, 1, 4'd9, 32'h0101_0101, "R2");
        beat(1, 0, 0, 1, 1, 4'd9, 32'h0202_0202, "R2");

        // R11: boundary indices, neighbour untouched
        beat(1, 0, 1, 0, 0, 4'd15, 32'h7FFF_FFFE, "R11");
        beat(1, 0, 1, 0, 0, 4'd0, 32'h0000_0055, "R11");
        beat(1, 1, 1, 0, 0, 4'd15, '0, "R11");
        beat(1, 1, 0, 0, 0, 4'd15, '0, "R8");
        beat(1, 1, 1, 0, 0, 4'd0, '0, "R11");
        beat(1, 1, 1, 0, 0, 4'd3, '0, "R11");
        beat(1, 1, 0, 0, 0, 4'd14, '0, "R11");

        // R12: no response while idle
        idle(4);
        n_chk++;
        if (rsp_valid !== 1'b0) fail_line("R12", $sformatf("got rsp_valid=%0d when idle, expected 0", rsp_valid));
        finish_run();
    end

endmodule